// File: doc/BRIEF.md
# Exception Entry State Controller

This block performs the architectural state update a 32-bit core makes on the cycle it takes an exception. The pipeline presents a one-cycle request with a fault class, the faulting PC, the next PC and the live Status, Cause and shadow-set control values. On the following clock edge the block presents the rewritten register values, each with its own write strobe, together with the handler address and a redirect strobe. The surrounding core commits the values whose strobes are set.

A separate reset request bypasses the exception bookkeeping. It sends the PC to the reset handler and marks coprocessor 1 usable. It leaves the exception program counter, Cause and the exception-level bit alone. When both requests arrive in the same cycle, reset wins.

The block has no memory of its own beyond its output registers. A data output keeps its last value until its strobe fires again.

Top module: `exc_entry_ctl`

## Requirements
- R1: While rst_n is low, and after it is released with no request, every strobe output is 0 and every data output is 0.
- R2: On an exception, status_out equals status_in with bit 1 (exception level) set, even if that bit was already 1, and we_status is 1.
- R3: The instruction counts as a delay-slot instruction when npc_in differs from pc_in + 4 (32-bit wrap-around). cause_out bit 31 then carries 1, and 0 otherwise.
- R4: On an exception, epc_out becomes pc_in, or pc_in - 4 (wrapping) for a delay-slot instruction, and we_epc is 1.
- R5: On an exception, cause_out bits 6:2 hold the code of the class and bits 29:28 are 0. All other bits come from cause_in except bit 31, and we_cause is 1. The class encodings and codes are: 0 interrupt gives 0, 1 syscall gives 8, 2 reserved instruction gives 10, 3 overflow gives 12, 4 trap gives 13, 5 breakpoint gives 9, 6 machine check gives 24, 7 coprocessor unusable gives 11, 8 address error gives 0, 9 TLB refill gives 0, 10 TLB invalid gives 0, 11 TLB modified gives 1. Encodings 12 to 15 give 0.
- R6: When status_in bits 1 (exception level) and 22 (bootstrap vectors) are both 0, an exception rotates the shadow-set control, and we_srsctl is 1. Bits 9:6 receive srsctl_in bits 3:0, bits 3:0 receive srsctl_in bits 15:12, and the other bits pass through. If either status bit is set, we_srsctl is 0 and srsctl_out keeps its previous value.
- R7: On an exception, pc_out is a base plus an offset and redirect is 1. The base is 0x80000000 when status_in bit 22 is 0 and 0xBFC00200 when it is 1. The offset is 0x000 for class 0 and 0x180 for every other encoding.
- R8: A reset request sets pc_out to 0xBFC00000 and sets status_out to status_in with bit 29 set and bit 1 unchanged. redirect and we_status are 1, and we_cause, we_epc and we_srsctl are 0. epc_out, cause_out and srsctl_out keep their values.
- R9: When rst_req and exc_req are high in the same cycle, the result is that of the reset request alone.
- R10: All results appear on the first clock edge after the request. A cycle with no request leaves every strobe 0 on the next edge and every data output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_cls | input | 4 | Fault class encoding |
| rst_req | input | 1 | One-cycle reset-handler request |
| pc_in | input | 32 | PC of the faulting instruction |
| npc_in | input | 32 | Next PC |
| status_in | input | 32 | Current Status value |
| cause_in | input | 32 | Current Cause value |
| srsctl_in | input | 32 | Current shadow-set control value |
| redirect | output | 1 | pc_out is a new fetch address |
| pc_out | output | 32 | Handler address |
| we_status | output | 1 | status_out is to be written |
| status_out | output | 32 | New Status value |
| we_cause | output | 1 | cause_out is to be written |
| cause_out | output | 32 | New Cause value |
| we_epc | output | 1 | epc_out is to be written |
| epc_out | output | 32 | New exception PC |
| we_srsctl | output | 1 | srsctl_out is to be written |
| srsctl_out | output | 32 | New shadow-set control value |

## Verification
Every fault class is applied with and without a delay slot, and under all four combinations of the exception-level and bootstrap bits. A design that gated the shadow-set rotation on only one of those bits, or that used the wrong vector base or offset, therefore shows a wrong srsctl_out or pc_out for some class. Directed cases cover the wrap-around points. At PC 0xFFFFFFFC with next PC 0 the instruction is not in a delay slot, while at PC 0 in a delay slot the EPC becomes 0xFFFFFFFC; a plain inequality or a missing modulo would flag the wrong bit or produce a wrong EPC. A reset request, alone or together with an exception, must leave EPC, Cause and the exception-level bit untouched, so a design that let the exception path leak through would change epc_out or set bit 1.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XW = 32;

  // Status field positions
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;

  // Cause field positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_W  = 5;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_W    = 2;
  localparam int CA_BD      = 31;

  // Shadow-set control field positions
  localparam int SRS_W      = 4;
  localparam int SRS_CUR_LO = 0;
  localparam int SRS_PRV_LO = 6;
  localparam int SRS_EXC_LO = 12;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    FC_INT    = 4'd0,
    FC_SYSC   = 4'd1,
    FC_RSVD   = 4'd2,
    FC_OVF    = 4'd3,
    FC_TRAP   = 4'd4,
    FC_BRK    = 4'd5,
    FC_MCHK   = 4'd6,
    FC_COPU   = 4'd7,
    FC_ADDR   = 4'd8,
    FC_TLBR   = 4'd9,
    FC_TLBI   = 4'd10,
    FC_TLBM   = 4'd11
  } fault_cls_e;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_entry_pkg::*;
(
  input  logic [CLS_W-1:0]     cls,
  output logic [CA_CODE_W-1:0] code,
  output logic                 gen_off
);
  always_comb begin
    gen_off = 1'b1;
    code    = '0;
    case (cls)
      FC_INT:  begin code = 5'd0;  gen_off = 1'b0; end
      FC_SYSC: code = 5'd8;
      FC_RSVD: code = 5'd10;
      FC_OVF:  code = 5'd12;
      FC_TRAP: code = 5'd13;
      FC_BRK:  code = 5'd9;
      FC_MCHK: code = 5'd24;
      FC_COPU: code = 5'd11;
      FC_TLBM: code = 5'd1;
      default: code = 5'd0;
    endcase
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] BASE_NORM = 32'h8000_0000,
  parameter logic [31:0] BASE_BOOT = 32'hBFC0_0200,
  parameter logic [31:0] GEN_OFF   = 32'h0000_0180
) (
  input  logic            bev,
  input  logic            gen_off,
  output logic [XLEN-1:0] vec
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;

  always_comb begin
    base = bev ? XLEN'(BASE_BOOT) : XLEN'(BASE_NORM);
    off  = gen_off ? XLEN'(GEN_OFF) : '0;
    vec  = base + off;
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]      pc,
  input  logic [XLEN-1:0]      npc,
  input  logic [XLEN-1:0]      status,
  input  logic [XLEN-1:0]      cause,
  input  logic [XLEN-1:0]      srsctl,
  input  logic [CA_CODE_W-1:0] code,
  output logic [XLEN-1:0]      status_nx,
  output logic [XLEN-1:0]      cause_nx,
  output logic [XLEN-1:0]      epc_nx,
  output logic [XLEN-1:0]      srsctl_nx,
  output logic                 rotate
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic in_slot;

  always_comb begin
    in_slot = (npc != (pc + STEP));
    epc_nx  = in_slot ? (pc - STEP) : pc;

    status_nx         = status;
    status_nx[ST_EXL] = 1'b1;

    cause_nx                             = cause;
    cause_nx[CA_CODE_LO +: CA_CODE_W]    = code;
    cause_nx[CA_CE_LO +: CA_CE_W]        = '0;
    cause_nx[CA_BD]                      = in_slot;

    rotate    = ~status[ST_EXL] & ~status[ST_BEV];
    srsctl_nx = srsctl;
    srsctl_nx[SRS_PRV_LO +: SRS_W] = srsctl[SRS_CUR_LO +: SRS_W];
    srsctl_nx[SRS_CUR_LO +: SRS_W] = srsctl[SRS_EXC_LO +: SRS_W];
  end
endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter int          SYNC_DEPTH = 2,
  parameter logic [31:0] BASE_NORM  = 32'h8000_0000,
  parameter logic [31:0] BASE_BOOT  = 32'hBFC0_0200,
  parameter logic [31:0] GEN_OFF    = 32'h0000_0180,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [3:0]       exc_cls,
  input  logic             rst_req,
  input  logic [XLEN-1:0]  pc_in,
  input  logic [XLEN-1:0]  npc_in,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  cause_in,
  input  logic [XLEN-1:0]  srsctl_in,
  output logic             redirect,
  output logic [XLEN-1:0]  pc_out,
  output logic             we_status,
  output logic [XLEN-1:0]  status_out,
  output logic             we_cause,
  output logic [XLEN-1:0]  cause_out,
  output logic             we_epc,
  output logic [XLEN-1:0]  epc_out,
  output logic             we_srsctl,
  output logic [XLEN-1:0]  srsctl_out
);
  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_DEPTH-1];

  // combinational datapath
  logic [CA_CODE_W-1:0] code;
  logic                 gen_off;
  logic [XLEN-1:0]      vec;
  logic [XLEN-1:0]      status_x, cause_x, epc_x, srsctl_x;
  logic                 rotate;

  exc_class_decode u_decode (
    .cls     (exc_cls),
    .code    (code),
    .gen_off (gen_off)
  );

  exc_vector_sel #(
    .XLEN      (XLEN),
    .BASE_NORM (BASE_NORM),
    .BASE_BOOT (BASE_BOOT),
    .GEN_OFF   (GEN_OFF)
  ) u_vec (
    .bev     (status_in[ST_BEV]),
    .gen_off (gen_off),
    .vec     (vec)
  );

  exc_state_calc #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES)
  ) u_calc (
    .pc        (pc_in),
    .npc       (npc_in),
    .status    (status_in),
    .cause     (cause_in),
    .srsctl    (srsctl_in),
    .code      (code),
    .status_nx (status_x),
    .cause_nx  (cause_x),
    .epc_nx    (epc_x),
    .srsctl_nx (srsctl_x),
    .rotate    (rotate)
  );

  // next-state selection
  logic            redir_d, wst_d, wca_d, wep_d, wsr_d;
  logic [XLEN-1:0] pc_d, st_d;

  always_comb begin
    redir_d = 1'b0;
    wst_d   = 1'b0;
    wca_d   = 1'b0;
    wep_d   = 1'b0;
    wsr_d   = 1'b0;
    pc_d    = vec;
    st_d    = status_x;
    if (rst_req) begin
      redir_d      = 1'b1;
      wst_d        = 1'b1;
      pc_d         = XLEN'(RESET_VEC);
      st_d         = status_in;
      st_d[ST_CU1] = 1'b1;
    end else if (exc_req) begin
      redir_d = 1'b1;
      wst_d   = 1'b1;
      wca_d   = 1'b1;
      wep_d   = 1'b1;
      wsr_d   = rotate;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redirect  <= 1'b0;
      we_status <= 1'b0;
      we_cause  <= 1'b0;
      we_epc    <= 1'b0;
      we_srsctl <= 1'b0;
    end else begin
      redirect  <= redir_d;
      we_status <= wst_d;
      we_cause  <= wca_d;
      we_epc    <= wep_d;
      we_srsctl <= wsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_out     <= '0;
      status_out <= '0;
      cause_out  <= '0;
      epc_out    <= '0;
      srsctl_out <= '0;
    end else begin
      if (redir_d) pc_out     <= pc_d;
      if (wst_d)   status_out <= st_d;
      if (wca_d)   cause_out  <= cause_x;
      if (wep_d)   epc_out    <= epc_x;
      if (wsr_d)   srsctl_out <= srsctl_x;
    end
  end
endmodule

// File: rtl/exc_entry_ctl_chk.sv
module exc_entry_ctl_chk
  import exc_entry_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            rst_req,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] npc_in,
  input logic [XLEN-1:0] status_in,
  input logic [XLEN-1:0] cause_in,
  input logic [XLEN-1:0] srsctl_in,
  input logic            redirect,
  input logic [XLEN-1:0] pc_out,
  input logic            we_status,
  input logic [XLEN-1:0] status_out,
  input logic            we_cause,
  input logic [XLEN-1:0] cause_out,
  input logic            we_epc,
  input logic [XLEN-1:0] epc_out,
  input logic            we_srsctl,
  input logic [XLEN-1:0] srsctl_out
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // R2
  exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !rst_req) |=> (we_status && status_out[ST_EXL]));

  // R4
  epc_noslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !rst_req && npc_in == pc_in + STEP) |=> (we_epc && epc_out == $past(pc_in)));

  // R5
  cause_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !rst_req) |=>
      (cause_out[CA_CE_LO +: CA_CE_W] == '0 && cause_out[27:7] == $past(cause_in[27:7])));

  // R6
  srs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !rst_req && (status_in[ST_EXL] || status_in[ST_BEV])) |=>
      (!we_srsctl && $stable(srsctl_out)));

  // R6
  srs_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !rst_req && !status_in[ST_EXL] && !status_in[ST_BEV]) |=>
      (we_srsctl && srsctl_out[SRS_CUR_LO +: SRS_W] == $past(srsctl_in[SRS_EXC_LO +: SRS_W])));

  // R8
  rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (redirect && pc_out == XLEN'(RESET_VEC) && status_out[ST_CU1]
                 && !we_cause && !we_epc && !we_srsctl && $stable(epc_out)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !rst_req) |=> (!redirect && !we_status && !we_cause && $stable(pc_out)
                                && $stable(status_out)));
endmodule

bind exc_entry_ctl exc_entry_ctl_chk #(
  .XLEN       (XLEN),
  .INSN_BYTES (INSN_BYTES),
  .RESET_VEC  (RESET_VEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .exc_req    (exc_req),
  .rst_req    (rst_req),
  .pc_in      (pc_in),
  .npc_in     (npc_in),
  .status_in  (status_in),
  .cause_in   (cause_in),
  .srsctl_in  (srsctl_in),
  .redirect   (redirect),
  .pc_out     (pc_out),
  .we_status  (we_status),
  .status_out (status_out),
  .we_cause   (we_cause),
  .cause_out  (cause_out),
  .we_epc     (we_epc),
  .epc_out    (epc_out),
  .we_srsctl  (we_srsctl),
  .srsctl_out (srsctl_out)
);

// File: tb/exc_entry_ctl_bench.sv
module exc_entry_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_cls = '0;
  logic        rst_req = 1'b0;
  logic [31:0] pc_in = '0, npc_in = '0, status_in = '0, cause_in = '0, srsctl_in = '0;
  logic        redirect, we_status, we_cause, we_epc, we_srsctl;
  logic [31:0] pc_out, status_out, cause_out, epc_out, srsctl_out;

  always #10 clk = ~clk;

  exc_entry_ctl u_exc_entry_ctl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cls(exc_cls), .rst_req(rst_req),
    .pc_in(pc_in), .npc_in(npc_in), .status_in(status_in), .cause_in(cause_in),
    .srsctl_in(srsctl_in), .redirect(redirect), .pc_out(pc_out),
    .we_status(we_status), .status_out(status_out), .we_cause(we_cause),
    .cause_out(cause_out), .we_epc(we_epc), .epc_out(epc_out),
    .we_srsctl(we_srsctl), .srsctl_out(srsctl_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // row: {pc, status base, cause base, srsctl}; the class is the row index
  localparam logic [127:0] VEC_TBL [12] = '{
    {32'h0040_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_A0C3},
    {32'h0040_1234, 32'h1000_FF01, 32'hFFFF_FFFF, 32'h0000_5F21},
    {32'h8000_0100, 32'h0040_0010, 32'h4000_0300, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h3000_007C, 32'h0000_3007},
    {32'hFFFF_FFF8, 32'h2000_0000, 32'h0012_3400, 32'h1234_5678},
    {32'h1000_0004, 32'h0000_0004, 32'h8000_0000, 32'h0000_F00E},
    {32'h7FFF_FFFC, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_9999},
    {32'h00AB_CDE0, 32'h5A5A_5A5A, 32'hA5A5_A5A5, 32'h0000_6666},
    {32'hBFC0_0380, 32'h0000_00FF, 32'h0000_FF00, 32'h0000_C00C},
    {32'h0000_0010, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h0000_1111},
    {32'h0012_0008, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_EEEE},
    {32'hCAFE_0000, 32'h0000_0400, 32'h0000_0080, 32'h0000_2468}
  };

  // expected state kept by the bench
  logic [31:0] e_pc = '0, e_st = '0, e_ca = '0, e_epc = '0, e_srs = '0;

  function automatic logic [4:0] code_of(input logic [3:0] c);
    case (c)
      4'd1: return 5'd8;   4'd2: return 5'd10;  4'd3: return 5'd12;
      4'd4: return 5'd13;  4'd5: return 5'd9;   4'd6: return 5'd24;
      4'd7: return 5'd11;  4'd11: return 5'd1;
      default: return 5'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model an exception following R2..R7
  task automatic model_exc(input logic [3:0] c);
    logic slot;
    slot  = (npc_in != pc_in + 32'd4);
    e_pc  = (status_in[22] ? 32'hBFC0_0200 : 32'h8000_0000) + ((c == 4'd0) ? 32'h0 : 32'h180);
    e_st  = status_in | 32'h2;
    e_ca  = (cause_in & ~32'hB000_007C) | {slot, 2'b00, 22'd0, code_of(c), 2'b00};
    e_epc = slot ? pc_in - 32'd4 : pc_in;
    if (!status_in[1] && !status_in[22])
      e_srs = {srsctl_in[31:10], srsctl_in[3:0], srsctl_in[5:4], srsctl_in[15:12]};
  endtask

  task automatic check_all(input string tag, input logic r, input logic ws,
                           input logic wc, input logic we, input logic wr);
    chk({tag, " redirect"},  {31'd0, redirect},  {31'd0, r});
    chk({tag, " we_status"}, {31'd0, we_status}, {31'd0, ws});
    chk({tag, " we_cause"},  {31'd0, we_cause},  {31'd0, wc});
    chk({tag, " we_epc"},    {31'd0, we_epc},    {31'd0, we});
    chk({tag, " we_srsctl"}, {31'd0, we_srsctl}, {31'd0, wr});
    chk({tag, " pc_out"},     pc_out,     e_pc);
    chk({tag, " status_out"}, status_out, e_st);
    chk({tag, " cause_out"},  cause_out,  e_ca);
    chk({tag, " epc_out"},    epc_out,    e_epc);
    chk({tag, " srsctl_out"}, srsctl_out, e_srs);
  endtask

  task automatic do_exc(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [31:0] st, input logic [31:0] ca, input logic [31:0] sr,
                        input string tag);
    logic rot;
    @(negedge clk);
    exc_req = 1'b1; exc_cls = c; pc_in = pc; npc_in = npc;
    status_in = st; cause_in = ca; srsctl_in = sr;
    rot = !st[1] && !st[22];
    model_exc(c);
    @(negedge clk);
    exc_req = 1'b0;
    check_all(tag, 1'b1, 1'b1, 1'b1, 1'b1, rot);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pc, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check_all("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // table walk: every class, slot or not, all EXL/BEV combinations (R2..R7)
    for (int row = 0; row < 12; row++) begin
      for (int mode = 0; mode < 8; mode++) begin
        pc = VEC_TBL[row][127:96];
        st = (VEC_TBL[row][95:64] & ~32'h0040_0002) | {9'd0, mode[1], 20'd0, mode[0], 1'b0};
        do_exc(4'(row), pc, mode[2] ? pc + 32'h100 : pc + 32'd4, st,
               VEC_TBL[row][63:32], VEC_TBL[row][31:0], "R2 R3 R4 R5 R6 R7 table");
      end
    end

    // R3: wrap-around, next PC 0 after 0xFFFFFFFC is sequential
    do_exc(4'd1, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 32'h0000_1234, "R3 wrap no slot");
    chk("R3 bd bit", {31'd0, cause_out[31]}, 32'd0);
    // R4: PC 0 in a delay slot gives EPC 0xFFFFFFFC
    do_exc(4'd2, 32'h0, 32'h40, 32'h2, 32'h0, 32'h0, "R4 epc wrap");
    chk("R4 epc value", epc_out, 32'hFFFF_FFFC);
    // R5 R7: undefined class encodings
    do_exc(4'd13, 32'h100, 32'h104, 32'h0, 32'h0000_007C, 32'h0, "R5 R7 class 13");
    chk("R7 offset 0x180", pc_out, 32'h8000_0180);
    do_exc(4'd15, 32'h200, 32'h204, 32'h0040_0000, 32'h0, 32'h0, "R5 R7 class 15");

    // R10: idle cycle keeps data, strobes drop
    @(negedge clk);
    check_all("R10 idle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8: reset request alone
    @(negedge clk);
    rst_req = 1'b1; status_in = 32'h0000_0000; pc_in = 32'h1234_5678; npc_in = 32'h0;
    e_pc = 32'hBFC0_0000; e_st = 32'h2000_0000;
    @(negedge clk);
    rst_req = 1'b0;
    check_all("R8 reset request", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 exl untouched", {31'd0, status_out[1]}, 32'd0);

    // R9: reset request together with an exception
    @(negedge clk);
    rst_req = 1'b1; exc_req = 1'b1; exc_cls = 4'd1;
    status_in = 32'h0000_0010; pc_in = 32'h0000_4000; npc_in = 32'h0000_9000;
    cause_in = 32'hFFFF_FFFF; srsctl_in = 32'h0000_F00F;
    e_pc = 32'hBFC0_0000; e_st = 32'h2000_0010;
    @(negedge clk);
    rst_req = 1'b0; exc_req = 1'b0;
    check_all("R9 reset wins", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R1: reset in mid-operation clears everything again
    do_exc(4'd6, 32'h0000_0800, 32'h0000_0804, 32'h0, 32'h0, 32'h0000_3000, "R2 before reset");
    rst_n = 1'b0;
    #1;
    e_pc = '0; e_st = '0; e_ca = '0; e_epc = '0; e_srs = '0;
    check_all("R1 async reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule